// File: doc/BRIEF.md
# Instruction Fetch Micro Translation Cache

This block is a small, fully associative cache of address translations placed in front of a slower main translation table on the instruction fetch path. In the same cycle that a lookup is requested it compares a 20-bit virtual page number and a 6-bit address-space identifier against every stored entry. It returns a matched flag together with the complete 50-bit stored entry, so the fetch logic can compare its instruction cache tag without waiting a cycle.

Entries arrive whole from the main table whenever that table answers a fetch lookup with a hit. Translations whose valid flag is clear are kept and reported like any other entry, so the requester can raise an invalid-page fault without asking the main table again. A single-cycle flush empties the cache. A write whose key already matches an entry replaces that entry. Otherwise a new entry goes to the lowest free slot, or, when all slots are taken, to the slot named by a rotating victim pointer.

Top module: `itlb_micro_cache`

## Requirements
- R1: An entry is 50 bits: page number [19:0], frame number [39:20], address-space ID [45:40], noncacheable [46], dirty [47], valid [48], global [49]. On a hit, `hit_entry_o` carries the stored 50 bits unchanged.
- R2: A stored entry matches a lookup when its page number equals `chk_vpn_i` and either its global bit [49] is set or its address-space ID equals `chk_asid_i`.
- R3: The lookup result is combinational from the stored state. A write accepted at a clock edge is visible to lookups from the following cycle, and not in the cycle of the write.
- R4: When `chk_en_i` is low, or no entry matches, `hit_o` is 0 and `hit_entry_o` is all zeros.
- R5: An entry whose valid bit [48] is 0 is stored and matched like any other entry, and its contents are returned.
- R6: A write whose key matches no stored entry goes to the lowest-numbered free slot while any slot is free. The number of occupied slots grows by at most one per cycle.
- R7: With all slots occupied, a new write replaces the slot named by a victim pointer. The pointer is 0 after reset or flush and advances by one, wrapping, only after such a replacement.
- R8: A write whose page number and address-space ID match a stored entry under the R2 rule overwrites the lowest-numbered such entry. It allocates no new slot and does not move the victim pointer.
- R9: `flush_i` empties every slot at the next edge and takes priority over a write in the same cycle, which is then discarded.
- R10: Reset leaves every slot empty, so every lookup misses.
- R11: When more than one stored entry matches a lookup, the lowest-numbered slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard all cached translations |
| wr_en_i | input | 1 | Write strobe for a refill entry |
| wr_entry_i | input | 50 | Refill entry in the R1 layout |
| chk_en_i | input | 1 | Lookup strobe |
| chk_vpn_i | input | 20 | Lookup virtual page number |
| chk_asid_i | input | 6 | Lookup address-space ID |
| hit_o | output | 1 | Lookup matched |
| hit_entry_o | output | 50 | Matched entry, zero on a miss |

## Verification
On every cycle the assertions check that a miss or an idle strobe gives a zero result, and that any reported hit agrees with the request in page number and, for non-global entries, address-space ID. They also check that a flush leaves no slot occupied, that a write always leaves a slot occupied, and that occupancy grows by at most one slot per cycle. Which slot a refill lands in, the victim rotation, in-place overwrites, lowest-slot priority among duplicate matches and the one-cycle write-to-lookup latency can be shown only by the bench's scenarios. There a behavioural model predicts every lookup and the result is compared on each clock.

// File: rtl/itlb_micro_pkg.sv
package itlb_micro_pkg;

    localparam int VPN_W    = 20;
    localparam int PFN_W    = 20;
    localparam int ASID_W   = 6;

    localparam int VPN_LSB  = 0;
    localparam int PFN_LSB  = VPN_LSB + VPN_W;
    localparam int ASID_LSB = PFN_LSB + PFN_W;
    localparam int NC_BIT   = ASID_LSB + ASID_W;
    localparam int DIRTY_BIT  = NC_BIT + 1;
    localparam int VALID_BIT  = DIRTY_BIT + 1;
    localparam int GLOBAL_BIT = VALID_BIT + 1;
    localparam int ENTRY_W  = GLOBAL_BIT + 1;

    typedef logic [ENTRY_W-1:0] tlb_entry_t;
    typedef logic [VPN_W-1:0]   vpn_t;
    typedef logic [ASID_W-1:0]  asid_t;

    function automatic vpn_t entry_vpn(input tlb_entry_t e);
        return e[VPN_LSB +: VPN_W];
    endfunction

    function automatic asid_t entry_asid(input tlb_entry_t e);
        return e[ASID_LSB +: ASID_W];
    endfunction

    function automatic logic entry_global(input tlb_entry_t e);
        return e[GLOBAL_BIT];
    endfunction

endpackage

// File: rtl/itlb_tag_match.sv
module itlb_tag_match
    import itlb_micro_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic [ENTRIES-1:0]       occ_i,
    input  tlb_entry_t [ENTRIES-1:0] ent_i,
    input  vpn_t                     key_vpn_i,
    input  asid_t                    key_asid_i,
    output logic [ENTRIES-1:0]       match_o
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic vpn_eq;
        logic asid_ok;
        assign vpn_eq  = entry_vpn(ent_i[g]) == key_vpn_i;
        assign asid_ok = entry_global(ent_i[g]) || (entry_asid(ent_i[g]) == key_asid_i);
        assign match_o[g] = occ_i[g] && vpn_eq && asid_ok;
    end

endmodule

// File: rtl/itlb_first_set.sv
module itlb_first_set #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] vec_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);

    always_comb begin
        found_o = |vec_i;
        idx_o   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/itlb_victim_sel.sv
module itlb_victim_sel #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] occ_i,
    input  logic [ENTRIES-1:0] wmatch_i,
    input  logic [IDX_W-1:0]   ptr_i,
    output logic [IDX_W-1:0]   slot_o,
    output logic               use_ptr_o
);

    logic             hit_found;
    logic [IDX_W-1:0] hit_idx;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;

    itlb_first_set #(.ENTRIES(ENTRIES)) u_hit_pick (
        .vec_i   (wmatch_i),
        .found_o (hit_found),
        .idx_o   (hit_idx)
    );

    itlb_first_set #(.ENTRIES(ENTRIES)) u_free_pick (
        .vec_i   (~occ_i),
        .found_o (free_found),
        .idx_o   (free_idx)
    );

    always_comb begin
        use_ptr_o = 1'b0;
        if (hit_found) begin
            slot_o = hit_idx;
        end else if (free_found) begin
            slot_o = free_idx;
        end else begin
            slot_o    = ptr_i;
            use_ptr_o = 1'b1;
        end
    end

endmodule

// File: rtl/itlb_micro_cache.sv
module itlb_micro_cache
    import itlb_micro_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               wr_en_i,
    input  logic [ENTRY_W-1:0] wr_entry_i,
    input  logic               chk_en_i,
    input  logic [VPN_W-1:0]   chk_vpn_i,
    input  logic [ASID_W-1:0]  chk_asid_i,
    output logic               hit_o,
    output logic [ENTRY_W-1:0] hit_entry_o
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]       occ;
        logic [IDX_W-1:0]         ptr;
        tlb_entry_t [ENTRIES-1:0] ent;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [ENTRIES-1:0] occ_q;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] wr_match;
    logic               lk_found;
    logic [IDX_W-1:0]   lk_idx;
    logic [IDX_W-1:0]   wr_slot;
    logic               wr_use_ptr;

    assign occ_q = st_q.occ;

    // Lookup path: compare against every slot, pick lowest hit
    itlb_tag_match #(.ENTRIES(ENTRIES)) u_lookup_cmp (
        .occ_i      (occ_q),
        .ent_i      (st_q.ent),
        .key_vpn_i  (chk_vpn_i),
        .key_asid_i (chk_asid_i),
        .match_o    (lk_match)
    );

    itlb_first_set #(.ENTRIES(ENTRIES)) u_lookup_pick (
        .vec_i   (lk_match),
        .found_o (lk_found),
        .idx_o   (lk_idx)
    );

    // Refill path: detect an existing copy of the key
    itlb_tag_match #(.ENTRIES(ENTRIES)) u_refill_cmp (
        .occ_i      (occ_q),
        .ent_i      (st_q.ent),
        .key_vpn_i  (entry_vpn(wr_entry_i)),
        .key_asid_i (entry_asid(wr_entry_i)),
        .match_o    (wr_match)
    );

    itlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
        .occ_i     (occ_q),
        .wmatch_i  (wr_match),
        .ptr_i     (st_q.ptr),
        .slot_o    (wr_slot),
        .use_ptr_o (wr_use_ptr)
    );

    always_comb begin
        hit_o       = chk_en_i && lk_found;
        hit_entry_o = hit_o ? st_q.ent[lk_idx] : '0;
    end

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.occ = '0;
            st_d.ptr = '0;
        end else if (wr_en_i) begin
            st_d.ent[wr_slot] = wr_entry_i;
            st_d.occ[wr_slot] = 1'b1;
            if (wr_use_ptr) begin
                st_d.ptr = (st_q.ptr == LAST_IDX) ? '0 : st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/itlb_micro_cache_chk.sv
module itlb_micro_cache_chk
    import itlb_micro_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_i,
    input logic               wr_en_i,
    input logic               chk_en_i,
    input logic [VPN_W-1:0]   chk_vpn_i,
    input logic [ASID_W-1:0]  chk_asid_i,
    input logic               hit_o,
    input logic [ENTRY_W-1:0] hit_entry_o,
    input logic [ENTRIES-1:0] occ_q
);

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> hit_entry_o == '0); // R4

    AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> chk_en_i); // R4

    AST_HIT_PAGE_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> hit_entry_o[VPN_LSB +: VPN_W] == chk_vpn_i); // R2

    AST_HIT_ASID_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && !hit_entry_o[GLOBAL_BIT]) |-> hit_entry_o[ASID_LSB +: ASID_W] == chk_asid_i); // R2

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> occ_q == '0); // R9

    AST_WRITE_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !flush_i) |=> occ_q != '0); // R6

    AST_GROW_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i |=> $countones(occ_q) <= $countones($past(occ_q)) + 1); // R6

endmodule

bind itlb_micro_cache itlb_micro_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .wr_en_i     (wr_en_i),
    .chk_en_i    (chk_en_i),
    .chk_vpn_i   (chk_vpn_i),
    .chk_asid_i  (chk_asid_i),
    .hit_o       (hit_o),
    .hit_entry_o (hit_entry_o),
    .occ_q       (occ_q)
);

// File: tb/tb_itlb_micro_cache.sv
`timescale 1ns/1ps
module tb_itlb_micro_cache;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [49:0] wr_entry_i = '0;
    logic        chk_en_i = 1'b0;
    logic [19:0] chk_vpn_i = '0;
    logic [5:0]  chk_asid_i = '0;
    logic        hit_o;
    logic [49:0] hit_entry_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural model
    logic [49:0] m_ent [N];
    bit          m_occ [N];
    int          m_ptr;

    always #2 clk = ~clk;

    itlb_micro_cache #(.ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .wr_en_i(wr_en_i),
        .wr_entry_i(wr_entry_i), .chk_en_i(chk_en_i), .chk_vpn_i(chk_vpn_i),
        .chk_asid_i(chk_asid_i), .hit_o(hit_o), .hit_entry_o(hit_entry_o)
    );

    function automatic logic [49:0] mk(input logic [19:0] vpn, input logic [19:0] pfn,
                                       input logic [5:0] asid, input bit valid, input bit glob);
        return {glob, valid, 1'b1, 1'b0, asid, pfn, vpn};
    endfunction

    function automatic bit key_hit(input logic [49:0] e, input logic [19:0] v, input logic [5:0] a);
        return (e[19:0] == v) && (e[49] || e[45:40] == a);
    endfunction

    function automatic int model_find(input logic [19:0] v, input logic [5:0] a);
        for (int i = 0; i < N; i++) begin
            if (m_occ[i] && key_hit(m_ent[i], v, a)) return i;
        end
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_occ[i] = 0;
            m_ent[i] = '0;
        end
        m_ptr = 0;
    endtask

    task automatic model_update(input bit fl, input bit wr, input logic [49:0] e);
        int slot;
        if (fl) begin
            for (int i = 0; i < N; i++) m_occ[i] = 0;
            m_ptr = 0;
        end else if (wr) begin
            slot = model_find(e[19:0], e[45:40]);
            if (slot < 0) begin
                for (int i = N - 1; i >= 0; i--) if (!m_occ[i]) slot = i;
            end
            if (slot < 0) begin
                slot = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_ent[slot] = e;
            m_occ[slot] = 1;
        end
    endtask

    task automatic compare(input string tag);
        int idx;
        bit exp_hit;
        logic [49:0] exp_ent;
        idx = chk_en_i ? model_find(chk_vpn_i, chk_asid_i) : -1;
        exp_hit = (idx >= 0);
        exp_ent = exp_hit ? m_ent[idx] : '0;
        checks++;
        if (hit_o !== exp_hit || hit_entry_o !== exp_ent) begin
            errors++;
            $display("FAIL %s hit=%0b entry=%h expected hit=%0b entry=%h",
                     tag, hit_o, hit_entry_o, exp_hit, exp_ent);
        end
    endtask

    task automatic step(input string tag, input bit fl, input bit wr, input logic [49:0] e,
                        input bit ck, input logic [19:0] v, input logic [5:0] a);
        @(negedge clk);
        flush_i = fl; wr_en_i = wr; wr_entry_i = e;
        chk_en_i = ck; chk_vpn_i = v; chk_asid_i = a;
        #1;
        compare(tag);
        @(posedge clk);
        model_update(fl, wr, e);
    endtask

    task automatic look(input string tag, input logic [19:0] v, input logic [5:0] a);
        step(tag, 0, 0, '0, 1, v, a);
    endtask

    task automatic put(input string tag, input logic [49:0] e);
        step(tag, 0, 1, e, 0, '0, '0);
    endtask

    // expects a specific outcome, on top of the model comparison
    task automatic expect_hit(input string tag, input bit want, input logic [19:0] want_pfn);
        checks++;
        if (hit_o !== want || (want && hit_entry_o[39:20] !== want_pfn)) begin
            errors++;
            $display("FAIL %s hit=%0b pfn=%h expected hit=%0b pfn=%h",
                     tag, hit_o, hit_entry_o[39:20], want, want_pfn);
        end
    endtask

    task automatic probe(input string tag, input logic [19:0] v, input logic [5:0] a,
                         input bit want, input logic [19:0] want_pfn);
        @(negedge clk);
        flush_i = 0; wr_en_i = 0; chk_en_i = 1; chk_vpn_i = v; chk_asid_i = a;
        #1;
        compare(tag);
        expect_hit(tag, want, want_pfn);
        @(posedge clk);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                errors++;
                $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [49:0] ea, eg, ei, ed, ee, ef, ee2, eh, ex, ey, ez;
        model_reset();
        ea  = mk(20'h00010, 20'hA0001, 6'd3, 1, 0);
        eg  = mk(20'h00020, 20'hA0002, 6'd1, 1, 1);
        ei  = mk(20'h00030, 20'hA0003, 6'd3, 0, 0);
        ed  = mk(20'h00040, 20'hA0004, 6'd3, 1, 0);
        ee  = mk(20'h00050, 20'hA0005, 6'd3, 1, 0);
        ef  = mk(20'h00060, 20'hA0006, 6'd3, 1, 0);
        ee2 = mk(20'h00050, 20'hB0005, 6'd3, 1, 0);
        eh  = mk(20'h00070, 20'hA0007, 6'd3, 1, 0);
        ex  = mk(20'h00080, 20'hC0001, 6'd1, 1, 0);
        ey  = mk(20'h00080, 20'hC0002, 6'd2, 1, 1);
        ez  = mk(20'h00090, 20'hC0003, 6'd1, 1, 0);

        // R10: lookups during and after reset miss
        repeat (2) @(negedge clk);
        chk_en_i = 1; chk_vpn_i = 20'h0; chk_asid_i = 6'd0;
        #1;
        expect_hit("R10 in reset", 0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        probe("R10 after reset", 20'h0, 6'd0, 0, '0);

        // R3: a write is not visible in its own cycle, visible the next
        step("R3 same cycle", 0, 1, ea, 1, 20'h00010, 6'd3);
        probe("R3 next cycle", 20'h00010, 6'd3, 1, 20'hA0001);
        // R1: full entry returned unchanged
        @(negedge clk);
        chk_en_i = 1; chk_vpn_i = 20'h00010; chk_asid_i = 6'd3; wr_en_i = 0;
        #1;
        checks++;
        if (hit_entry_o !== ea) begin
            errors++;
            $display("FAIL R1 entry=%h expected %h", hit_entry_o, ea);
        end
        @(posedge clk);

        // R2: address-space mismatch misses unless global
        probe("R2 asid differs", 20'h00010, 6'd4, 0, '0);
        put("R6 fill", eg);
        probe("R2 global any asid", 20'h00020, 6'd9, 1, 20'hA0002);

        // R5: entry with valid clear is stored and returned
        put("R6 fill", ei);
        probe("R5 invalid entry hit", 20'h00030, 6'd3, 1, 20'hA0003);
        checks++;
        @(negedge clk); chk_vpn_i = 20'h00030; #1;
        if (hit_entry_o[48] !== 1'b0) begin
            errors++;
            $display("FAIL R5 valid bit=%0b expected 0", hit_entry_o[48]);
        end
        @(posedge clk);

        // R4: strobe low gives zeros even on a matching key
        step("R4 strobe low", 0, 0, '0, 0, 20'h00010, 6'd3);
        checks++;
        if (hit_o !== 1'b0 || hit_entry_o !== '0) begin
            errors++;
            $display("FAIL R4 hit=%0b entry=%h expected 0 and 0", hit_o, hit_entry_o);
        end
        probe("R4 no match", 20'h00099, 6'd3, 0, '0);

        // R6 fill last slot, R7 round-robin replacement from slot 0
        put("R6 fill", ed);
        put("R7 replace slot0", ee);
        probe("R7 slot0 evicted", 20'h00010, 6'd3, 0, '0);
        probe("R7 new present", 20'h00050, 6'd3, 1, 20'hA0005);
        put("R7 replace slot1", ef);
        probe("R7 slot1 evicted", 20'h00020, 6'd1, 0, '0);

        // R8: overwrite in place, pointer unchanged
        put("R8 rewrite", ee2);
        probe("R8 new contents", 20'h00050, 6'd3, 1, 20'hB0005);
        probe("R8 no eviction", 20'h00030, 6'd3, 1, 20'hA0003);
        probe("R8 no eviction", 20'h00040, 6'd3, 1, 20'hA0004);
        put("R7 replace slot2", eh);
        probe("R7 slot2 evicted", 20'h00030, 6'd3, 0, '0);
        probe("R8 rewritten kept", 20'h00050, 6'd3, 1, 20'hB0005);

        // R11: duplicate matches resolve to the lowest slot
        step("R9 flush", 1, 0, '0, 0, '0, '0);
        probe("R9 emptied", 20'h00050, 6'd3, 0, '0);
        put("R11 fill", ex);
        put("R11 fill", ey);
        probe("R11 lowest wins", 20'h00080, 6'd1, 1, 20'hC0001);
        probe("R11 global only", 20'h00080, 6'd2, 1, 20'hC0002);

        // R9: flush beats a simultaneous write
        step("R9 flush with write", 1, 1, ez, 0, '0, '0);
        probe("R9 write dropped", 20'h00090, 6'd1, 0, '0);
        probe("R9 old gone", 20'h00080, 6'd1, 0, '0);

        // R2/R6/R7/R8 mixed traffic compared against the model
        for (int i = 0; i < 2000; i++) begin
            logic [49:0] e;
            bit fl, wr;
            e = mk(20'(20'h00100 + $urandom_range(0, 7)), 20'($urandom),
                   6'($urandom_range(0, 2)), 1'($urandom), 1'($urandom_range(0, 3) == 0));
            fl = ($urandom_range(0, 40) == 0);
            wr = ($urandom_range(0, 2) == 0);
            step("R2 mixed", fl, wr, e, 1'($urandom_range(0, 5) != 0),
                 20'(20'h00100 + $urandom_range(0, 7)), 6'($urandom_range(0, 2)));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule